// File: doc/BRIEF.md
# Programmable Interrupt Router

This block collects single-cycle event strobes from elsewhere in the chip and routes each one to one of three active-low general-purpose interrupt lines. A 2-bit route field per event picks the line, and route code 0 drops the event entirely. Every line has its own status register that records which events have arrived. Reading that register returns the recorded bits and clears them. Each line also has a mask bit and a mode bit. The mask gates only the pin, so events keep being recorded while a line is masked. In level mode the pin stays low while unmasked status is pending. In pulse mode the pin drops for one microsecond, timed by a cycle counter sized from the clock frequency.

A separate active-low error line is driven from an error status register fed by level-type fault conditions. The mask register has no effect on the error line. An error bit is set when its condition rises. It clears when the error register is read or when the condition goes away. The line returns high once every error bit is clear.

Control, mask, route table and status are reached through a small register port. Writes take effect on the next clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_router`

## Requirements
- R1: After reset, `irq_n` is 3'b111 and `err_n` is 1. The mode register (address 0), the mask register (address 1) and the route register (address 2) all read back 0, so every event is dropped and every line is in level mode.
- R2: Event e is routed by bits [2e+1:2e] of the route register. A code of 1, 2 or 3 sets bit e of status register 1, 2 or 3 (addresses 4, 5, 6). A code of 0 sets no status bit anywhere.
- R3: A read of status address 4, 5 or 6 returns the recorded bits one cycle after the strobe and clears them. An event arriving in the same cycle as that read is kept and is returned by the next read.
- R4: In level mode (mode bit k-1 = 0 for line k), `irq_n[k-1]` is low from the second clock edge after an unmasked event while the status is nonzero. It returns high after the status read clears it.
- R5: Mask bit k-1 = 1 holds `irq_n[k-1]` high, but status still records events. In level mode, clearing the mask with events pending drives the pin low.
- R6: In pulse mode (mode bit k-1 = 1), an unmasked routed event drives `irq_n[k-1]` low for exactly CLK_MHZ*PULSE_US cycles (16 by default). The pin then returns high even though the status bits stay set.
- R7: An event arriving while a pulse is in progress does not lengthen or restart the pulse, but its status bit is still recorded.
- R8: `err_n` is low whenever any error status bit is set. Writing the mask register does not affect it.
- R9: Error bit i is set on a rising edge of `err_cond[i]`. It clears when the error register (address 7) is read, returning the bits, or when `err_cond[i]` is low. A rise that coincides with the read is kept.
- R10: The mode, mask and route registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | N_EVT | One-cycle event strobes |
| err_cond | input | N_ERR | Fault condition levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_n | output | 3 | Active-low interrupt lines; bit 0 is line 1 |
| err_n | output | 1 | Active-low nonmaskable error line |

## Verification
A status bit that is recorded in the wrong bank, or is lost, shows up at the status read one cycle after the strobe. In level mode it also shows on the pin two edges after the event. A faulty pulse counter shows as a pin low time that differs from 16 cycles, either a shortened or a stretched pulse within the same microsecond window. A stuck error bit keeps `err_n` low two edges after every condition has dropped.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int N_LINE = 3;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_ERR   = 3'd7;

  typedef logic [1:0] route_t;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_router_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [N_LINE-1:0]      mode_q,
  output logic [N_LINE-1:0]      mask_q,
  output logic [2*N_EVT-1:0]     route_q
);
  localparam int MAP_W = 2 * N_EVT;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      case (addr)
        A_MODE:  mode_q  <= wdata[N_LINE-1:0];
        A_MASK:  mask_q  <= wdata[N_LINE-1:0];
        A_ROUTE: route_q <= wdata[MAP_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_router_pkg::*;
#(
  parameter int N_EVT   = 8,
  parameter int LINE_ID = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EVT-1:0]   evt,
  input  logic [2*N_EVT-1:0] route,
  input  logic               rd_clr,
  output logic [N_EVT-1:0]   stat_q,
  output logic               hit
);
  logic [N_EVT-1:0] sel;

  for (genvar e = 0; e < N_EVT; e++) begin : g_sel
    route_t code;
    assign code   = route[2*e +: 2];
    assign sel[e] = evt[e] && (code == route_t'(LINE_ID));
  end

  assign hit = |sel;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (rd_clr ? '0 : stat_q) | sel;
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_mode,
  input  logic masked,
  input  logic pending,
  input  logic hit,
  output logic pin_n
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start = pulse_mode && !masked && hit && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             pin_n <= 1'b1;
    else if (pulse_mode) pin_n <= (cnt_q == '0);
    else                 pin_n <= !(pending && !masked);
  end
endmodule

// File: rtl/irq_err_bank.sv
module irq_err_bank #(
  parameter int N_ERR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ERR-1:0] cond,
  input  logic             rd_clr,
  output logic [N_ERR-1:0] stat_q,
  output logic             err_n
);
  logic [N_ERR-1:0] cond_q;
  logic [N_ERR-1:0] rise;

  assign rise = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      stat_q <= '0;
      err_n  <= 1'b1;
    end else begin
      cond_q <= cond;
      stat_q <= ((rd_clr ? '0 : stat_q) & cond) | rise;
      err_n  <= ~(|stat_q);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_EVT    = 8,
  parameter int N_ERR    = 4,
  parameter int CLK_MHZ  = 16,
  parameter int PULSE_US = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt,
  input  logic [N_ERR-1:0]  err_cond,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [2:0]        irq_n,
  output logic              err_n
);
  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

  logic [N_LINE-1:0]             mode_q;
  logic [N_LINE-1:0]             mask_q;
  logic [2*N_EVT-1:0]            route_q;
  logic [N_LINE-1:0][N_EVT-1:0]  stat_all;
  logic [N_ERR-1:0]              err_stat;
  logic                          err_clr;
  logic [REG_W-1:0]              rd_mux;

  irq_ctrl_regs #(.N_EVT(N_EVT)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mode_q(mode_q), .mask_q(mask_q), .route_q(route_q)
  );

  for (genvar k = 0; k < N_LINE; k++) begin : g_line
    logic rd_clr;
    logic hit;
    assign rd_clr = reg_rd && (reg_addr == A_STAT1 + ADDR_W'(k));

    irq_status_bank #(.N_EVT(N_EVT), .LINE_ID(k + 1)) u_stat (
      .clk(clk), .rst(rst), .evt(evt), .route(route_q), .rd_clr(rd_clr),
      .stat_q(stat_all[k]), .hit(hit)
    );

    irq_pin_drive #(.PULSE_CYC(PULSE_CYC)) u_pin (
      .clk(clk), .rst(rst), .pulse_mode(mode_q[k]), .masked(mask_q[k]),
      .pending(|stat_all[k]), .hit(hit), .pin_n(irq_n[k])
    );
  end

  assign err_clr = reg_rd && (reg_addr == A_ERR);

  irq_err_bank #(.N_ERR(N_ERR)) u_err (
    .clk(clk), .rst(rst), .cond(err_cond), .rd_clr(err_clr),
    .stat_q(err_stat), .err_n(err_n)
  );

  always_comb begin
    case (reg_addr)
      A_MODE:         rd_mux = REG_W'(mode_q);
      A_MASK:         rd_mux = REG_W'(mask_q);
      A_ROUTE:        rd_mux = REG_W'(route_q);
      A_STAT1:        rd_mux = REG_W'(stat_all[0]);
      A_STAT1 + 3'd1: rd_mux = REG_W'(stat_all[1]);
      A_STAT1 + 3'd2: rd_mux = REG_W'(stat_all[2]);
      A_ERR:          rd_mux = REG_W'(err_stat);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int N_EVT     = 8,
  parameter int N_ERR     = 4,
  parameter int PULSE_CYC = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic [N_EVT-1:0]                evt,
  input logic [N_ERR-1:0]                err_cond,
  input logic                            reg_rd,
  input logic [2:0]                      reg_addr,
  input logic [2:0]                      irq_n,
  input logic                            err_n,
  input logic [N_LINE-1:0]               mode_q,
  input logic [N_LINE-1:0]               mask_q,
  input logic [N_LINE-1:0][N_EVT-1:0]    stat_all
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n == 3'b111) && err_n);

  assert_err_release_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(err_cond, 2) == '0) && ($past(err_cond) == '0) |-> err_n);

  for (genvar k = 0; k < N_LINE; k++) begin : g_chk
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
      if (rst)                       low_run <= '0;
      else if (!irq_n[k] && mode_q[k]) low_run <= low_run + 16'd1;
      else                           low_run <= '0;
    end

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
      low_run <= 16'(PULSE_CYC));

    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      $past(!mode_q[k] && mask_q[k]) |-> irq_n[k]);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
      $past(reg_rd && (reg_addr == A_STAT1 + 3'(k)) && (evt == '0))
        |-> (stat_all[k] == '0));
  end
endmodule

bind irq_router irq_router_chk #(
  .N_EVT(N_EVT), .N_ERR(N_ERR), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .err_cond(err_cond), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .irq_n(irq_n), .err_n(err_n), .mode_q(mode_q),
  .mask_q(mask_q), .stat_all(stat_all)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt = '0;
  logic [3:0]  err_cond = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  irq_n;
  logic        err_n;

  int total = 0;
  int bad   = 0;
  logic [15:0] rv;
  int lows;

  irq_router dut (
    .clk(clk), .rst(rst), .evt(evt), .err_cond(err_cond), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n), .err_n(err_n)
  );

  always #4 clk = ~clk;

  // {route16, mask3, evt8, stat1 8, stat2 8, stat3 8, irq_n 3}
  localparam logic [53:0] VEC [6] = '{
    {16'h5555, 3'b000, 8'h81, 8'h81, 8'h00, 8'h00, 3'b110},
    {16'hAAAA, 3'b000, 8'h0F, 8'h00, 8'h0F, 8'h00, 3'b101},
    {16'hFFFF, 3'b100, 8'h10, 8'h00, 8'h00, 8'h10, 3'b111},
    {16'h0000, 3'b000, 8'hFF, 8'h00, 8'h00, 8'h00, 3'b111},
    {16'h0039, 3'b000, 8'h0F, 8'h01, 8'h02, 8'h04, 3'b000},
    {16'h0039, 3'b011, 8'h06, 8'h00, 8'h02, 8'h04, 3'b011}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fire(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 irq_n", 32'(irq_n), 32'h7);
    check("R1 err_n", 32'(err_n), 32'h1);
    rd(3'd0, rv); check("R1 mode", 32'(rv), 32'h0);
    rd(3'd1, rv); check("R1 mask", 32'(rv), 32'h0);
    rd(3'd2, rv); check("R1 route", 32'(rv), 32'h0);

    // R10 readback
    wr(3'd0, 16'h0005); wr(3'd1, 16'h0006); wr(3'd2, 16'hBEEF);
    rd(3'd0, rv); check("R10 mode", 32'(rv), 32'h5);
    rd(3'd1, rv); check("R10 mask", 32'(rv), 32'h6);
    rd(3'd2, rv); check("R10 route", 32'(rv), 32'hBEEF);
    wr(3'd0, 16'h0000);

    // R2/R4/R5 table walk in level mode
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, VEC[i][53:38]);
      wr(3'd1, 16'(VEC[i][37:35]));
      fire(VEC[i][34:27]);
      idle(2);
      check("R4 R5 table pin", 32'(irq_n), 32'(VEC[i][2:0]));
      rd(3'd4, rv); check("R2 table stat1", 32'(rv), 32'(VEC[i][26:19]));
      rd(3'd5, rv); check("R2 table stat2", 32'(rv), 32'(VEC[i][18:11]));
      rd(3'd6, rv); check("R2 table stat3", 32'(rv), 32'(VEC[i][10:3]));
      idle(2);
      check("R4 pin released after read", 32'(irq_n), 32'h7);
    end

    // R5 unmask with pending event in level mode
    wr(3'd2, 16'h0005);
    wr(3'd1, 16'h0001);
    fire(8'h01);
    idle(3);
    check("R5 masked pin high", 32'(irq_n[0]), 32'h1);
    wr(3'd1, 16'h0000);
    idle(1);
    check("R5 unmask asserts pin", 32'(irq_n[0]), 32'h0);

    // R3 event in the same cycle as the status read is kept
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd4; evt = 8'h02;
    @(negedge clk);
    reg_rd = 1'b0; evt = '0;
    check("R3 read returns old bits", 32'(reg_rdata), 32'h01);
    rd(3'd4, rv); check("R3 coincident event kept", 32'(rv), 32'h02);
    rd(3'd4, rv); check("R3 cleared", 32'(rv), 32'h00);

    // R6/R7 pulse mode width, event during pulse
    wr(3'd0, 16'h0001);
    idle(2);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_n[0] == 1'b0) lows++;
      evt = (i == 0) ? 8'h01 : (i == 5) ? 8'h02 : 8'h00;
    end
    check("R6 R7 pulse low cycles", 32'(lows), 32'd16);
    check("R6 pin high with status set", 32'(irq_n[0]), 32'h1);
    rd(3'd4, rv); check("R7 status recorded during pulse", 32'(rv), 32'h03);
    wr(3'd0, 16'h0000);

    // R8/R9 error line
    @(negedge clk); err_cond = 4'b0010;
    idle(2);
    check("R8 err_n low", 32'(err_n), 32'h0);
    wr(3'd1, 16'h0007);
    idle(1);
    check("R8 mask has no effect", 32'(err_n), 32'h0);
    wr(3'd1, 16'h0000);
    rd(3'd7, rv); check("R9 read returns bits", 32'(rv), 32'h2);
    idle(1);
    check("R9 read clears with cond held", 32'(err_n), 32'h1);
    @(negedge clk); err_cond = 4'b0100;
    idle(2);
    check("R9 new rise sets", 32'(err_n), 32'h0);
    @(negedge clk); err_cond = 4'b0000;
    idle(2);
    check("R9 cond removal clears", 32'(err_n), 32'h1);
    @(negedge clk); err_cond = 4'b0001;
    idle(1);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd7; err_cond = 4'b1001;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R9 read data", 32'(reg_rdata), 32'h1);
    rd(3'd7, rv); check("R9 coincident rise kept", 32'(rv), 32'h8);
    err_cond = '0;
    idle(3);
    check("R8 err_n released", 32'(err_n), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule